// File: doc/BRIEF.md
# Hall-Sensor Six-Step Commutator

This block turns the three digital Hall-sensor levels of a three-phase brushless motor into six gate-enable signals for a three-phase half-bridge, one top and one bottom switch per phase. The sensor levels are first passed through a synchronizer. They are then checked against the invalid codes of the selected sensor spacing, folded onto a single commutation table, and inverted when reverse rotation is asked for. Each valid state then turns on one top and one bottom switch in two different phases.

Around the commutation table sit the override paths. Enable, brake, an overcurrent blanking flag and an undervoltage flag each force a defined gate pattern. The PWM input chops either the bottom switches alone or both the top and bottom switches, as the quadrature-select input chooses. A tachometer output gives one stretched pulse for every change seen on the synchronized sensor inputs. An active-low fault output reports disable, undervoltage and invalid sensor codes. All outputs are registered.

Top module: `hall_commutator`

## Requirements
- R1: While reset is asserted, gateTop and gateBot are 000, tachOut is 0 and faultN is 1.
- R2: The sensor code is {A,B,C} = hallIn[2:0] and the gate vectors are {A,B,C} = gate[2:0]. With spacing60 = 0, forward = 1, enable = 1, pwmIn = 1, and brake, overCurrent and underVolt all 0, the codes map to (top, bottom) as follows: 100→(100,010), 110→(100,001), 010→(010,001), 011→(010,100), 001→(001,100), 101→(001,010). faultN is 1 for each of these codes. A change on hallIn reaches the gates on the third rising clock edge after it is applied. A change on any other input takes effect on the next edge.
- R3: With spacing60 = 1, a sensor code h drives the gates exactly as the code h XOR 010 does in R2. For example, 000 drives (010,001) and 111 drives (001,010).
- R4: The invalid codes are 000 and 111 when spacing60 = 0, and 010 and 101 when spacing60 = 1. An invalid code drives faultN to 0. It turns all gates off when brake = 0. When brake = 1 it gives top 000 and bottom 111.
- R5: With forward = 0, the code is inverted bit by bit before the commutation table is applied, so the top and bottom phases swap. For example, with spacing60 = 0, code 100 gives (010,100).
- R6: With enable = 0, faultN is 0. All gates are off when brake = 0. When brake = 1 the gates are top 000 and bottom 111.
- R7: With brake = 1, enable = 1, a valid code and no undervoltage, the gates are top 000 and bottom 111 and faultN is 1. This holds even when overCurrent = 1.
- R8: With overCurrent = 1 and brake = 0, all six gates are off and faultN stays 1.
- R9: With quadSel = 1, pwmIn = 0 clears the bottom gate and leaves the top gate on. With quadSel = 0, pwmIn = 0 clears both gates. With pwmIn = 1, the gates follow R2.
- R10: Every change of the synchronized sensor code raises tachOut on the third rising edge after the change is applied to hallIn. tachOut stays high for TACH_CYCLES cycles. A further change while tachOut is high restarts the full width.
- R11: With underVolt = 1, all six gates are off and faultN is 0, whatever the state of brake.
- R12: A top gate and the bottom gate of the same phase are never on together, and at most one top gate is on at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hallIn | input | 3 | Raw Hall levels {A,B,C} |
| spacing60 | input | 1 | 1 selects 60-degree sensor spacing, 0 selects 120-degree spacing |
| forward | input | 1 | 1 forward rotation, 0 reverse rotation |
| enable | input | 1 | 1 allows commutation |
| quadSel | input | 1 | 1 chops the bottom gates only, 0 chops the top and bottom gates |
| pwmIn | input | 1 | PWM chopping input, high means on |
| brake | input | 1 | 1 forces the bottom gates on and the top gates off |
| overCurrent | input | 1 | Overcurrent blanking flag |
| underVolt | input | 1 | Undervoltage lockout flag |
| gateTop | output | 3 | Top gate enables {A,B,C} |
| gateBot | output | 3 | Bottom gate enables {A,B,C} |
| faultN | output | 1 | Active-low fault: disable, undervoltage or invalid code |
| tachOut | output | 1 | Stretched tachometer pulse |

## Verification
Some properties are checked on every cycle. No phase ever has both its switches on, and no more than one top switch is on. A low fault never goes with an energised top switch. Brake and undervoltage force their gate patterns one edge later. Every detected sensor change raises the tachometer output.

Other behaviour only the bench scenarios can show. These are the exact commutation table for each spacing and direction, the folding of the invalid codes, the PWM masking under each quadrature setting, the three-edge sensor latency, and the tachometer pulse width and its restart.

// File: rtl/hall_pkg.sv
package hall_pkg;

  localparam int PHASES = 3;

  typedef enum logic [1:0] {
    DRV_OFF   = 2'd0,
    DRV_BRAKE = 2'd1,
    DRV_RUN   = 2'd2
  } drive_e;

  // strobes from control to datapath
  typedef struct packed {
    drive_e             mode;
    logic               chopTop;
    logic               chopBot;
    logic [PHASES-1:0]  step;
  } cmd_t;

  // normalized (120-degree, forward) code to {top, bottom} gate vectors
  function automatic logic [2*PHASES-1:0] stepGates(input logic [PHASES-1:0] code);
    logic [2*PHASES-1:0] g;
    case (code)
      3'b100:  g = {3'b100, 3'b010};
      3'b110:  g = {3'b100, 3'b001};
      3'b010:  g = {3'b010, 3'b001};
      3'b011:  g = {3'b010, 3'b100};
      3'b001:  g = {3'b001, 3'b100};
      3'b101:  g = {3'b001, 3'b010};
      default: g = '0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/hall_sync.sv
module hall_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/hall_ctrl.sv
module hall_ctrl
  import hall_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TACH_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PHASES-1:0] hallIn,
  input  logic              spacing60,
  input  logic              forward,
  input  logic              enable,
  input  logic              quadSel,
  input  logic              pwmIn,
  input  logic              brake,
  input  logic              overCurrent,
  input  logic              underVolt,
  output cmd_t              cmd,
  output logic              faultN,
  output logic              tachOut
);

  localparam int TACH_W = $clog2(TACH_CYCLES + 1);
  localparam logic [TACH_W-1:0] TACH_LOAD = TACH_W'(TACH_CYCLES);
  localparam logic [PHASES-1:0] SPACING_FOLD = 3'b010;

  logic [PHASES-1:0] hallSync;
  logic [PHASES-1:0] hallPrev;
  logic [PHASES-1:0] normCode;
  logic [PHASES-1:0] stepCode;
  logic              codeOk;
  logic              hallEdge;
  logic [TACH_W-1:0] tachCnt;

  hall_sync #(.WIDTH(PHASES), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (hallIn),
    .dout (hallSync)
  );

  // fold 60-degree codes onto the 120-degree table; invalid codes become 000/111
  always_comb begin
    normCode = spacing60 ? (hallSync ^ SPACING_FOLD) : hallSync;
    codeOk   = (normCode != '0) && (normCode != '1);
    stepCode = normCode ^ {PHASES{~forward}};
  end

  always_comb begin
    cmd.step    = stepCode;
    cmd.chopBot = ~pwmIn;
    cmd.chopTop = ~pwmIn & ~quadSel;
    if (underVolt)                              cmd.mode = DRV_OFF;
    else if (brake)                             cmd.mode = DRV_BRAKE;
    else if (!enable || !codeOk || overCurrent) cmd.mode = DRV_OFF;
    else                                        cmd.mode = DRV_RUN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) faultN <= 1'b1;
    else       faultN <= ~(underVolt | ~enable | ~codeOk);
  end

  // tach pulse stretcher
  assign hallEdge = (hallSync != hallPrev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hallPrev <= '0;
      tachCnt  <= '0;
    end else begin
      hallPrev <= hallSync;
      if (hallEdge)          tachCnt <= TACH_LOAD;
      else if (tachCnt != 0) tachCnt <= tachCnt - 1'b1;
    end
  end

  assign tachOut = (tachCnt != 0);

  assert_tach_on_edge_R10: assert property (@(posedge clk) disable iff (!rstN)
    hallEdge |=> tachOut);

  assert_tach_fall_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tachOut) |-> !$past(hallEdge));

endmodule

// File: rtl/hall_datapath.sv
module hall_datapath
  import hall_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cmd_t              cmd,
  output logic [PHASES-1:0] gateTop,
  output logic [PHASES-1:0] gateBot
);

  logic [PHASES-1:0] runTop;
  logic [PHASES-1:0] runBot;

  always_comb begin
    {runTop, runBot} = stepGates(cmd.step);
    runTop = runTop & {PHASES{~cmd.chopTop}};
    runBot = runBot & {PHASES{~cmd.chopBot}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateTop <= '0;
      gateBot <= '0;
    end else begin
      case (cmd.mode)
        DRV_RUN: begin
          gateTop <= runTop;
          gateBot <= runBot;
        end
        DRV_BRAKE: begin
          gateTop <= '0;
          gateBot <= '1;
        end
        default: begin
          gateTop <= '0;
          gateBot <= '0;
        end
      endcase
    end
  end

  assert_no_shoot_through_R12: assert property (@(posedge clk) disable iff (!rstN)
    (gateTop & gateBot) == '0);

  assert_single_top_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gateTop));

endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hall_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TACH_CYCLES = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] hallIn,
  input  logic       spacing60,
  input  logic       forward,
  input  logic       enable,
  input  logic       quadSel,
  input  logic       pwmIn,
  input  logic       brake,
  input  logic       overCurrent,
  input  logic       underVolt,
  output logic [2:0] gateTop,
  output logic [2:0] gateBot,
  output logic       faultN,
  output logic       tachOut
);

  cmd_t cmd;

  hall_ctrl #(.SYNC_STAGES(SYNC_STAGES), .TACH_CYCLES(TACH_CYCLES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .hallIn      (hallIn),
    .spacing60   (spacing60),
    .forward     (forward),
    .enable      (enable),
    .quadSel     (quadSel),
    .pwmIn       (pwmIn),
    .brake       (brake),
    .overCurrent (overCurrent),
    .underVolt   (underVolt),
    .cmd         (cmd),
    .faultN      (faultN),
    .tachOut     (tachOut)
  );

  hall_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .gateTop (gateTop),
    .gateBot (gateBot)
  );

  assert_fault_no_top_R4: assert property (@(posedge clk) disable iff (!rstN)
    !faultN |-> (gateTop == '0));

  assert_uv_off_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(underVolt) |-> (gateTop == '0 && gateBot == '0));

  assert_brake_tops_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(brake && !underVolt) |-> (gateTop == '0 && gateBot == '1));

endmodule

// File: tb/hall_commutator_bench.sv
module hall_commutator_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TACH_N     = 5;
  localparam int NVEC       = 33;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] hallIn = 3'b100;
  logic       spacing60 = 1'b0, forward = 1'b1, enable = 1'b1, quadSel = 1'b1;
  logic       pwmIn = 1'b1, brake = 1'b0, overCurrent = 1'b0, underVolt = 1'b0;
  logic [2:0] gateTop, gateBot;
  logic       faultN, tachOut;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hall_commutator #(.SYNC_STAGES(2), .TACH_CYCLES(TACH_N)) u_hall_commutator (
    .clk(clk), .rstN(rstN), .hallIn(hallIn), .spacing60(spacing60),
    .forward(forward), .enable(enable), .quadSel(quadSel), .pwmIn(pwmIn),
    .brake(brake), .overCurrent(overCurrent), .underVolt(underVolt),
    .gateTop(gateTop), .gateBot(gateBot), .faultN(faultN), .tachOut(tachOut)
  );

  // req(4) s60 fwd en qs pwm brk oc uv hall(3) top(3) bot(3) faultN
  localparam logic [21:0] VEC [NVEC] = '{
    22'b0010_0_1_1_1_1_0_0_0_100_100_010_1, // R2
    22'b0010_0_1_1_1_1_0_0_0_110_100_001_1, // R2
    22'b0010_0_1_1_1_1_0_0_0_010_010_001_1, // R2
    22'b0010_0_1_1_1_1_0_0_0_011_010_100_1, // R2
    22'b0010_0_1_1_1_1_0_0_0_001_001_100_1, // R2
    22'b0010_0_1_1_1_1_0_0_0_101_001_010_1, // R2
    22'b0100_0_1_1_1_1_0_0_0_000_000_000_0, // R4
    22'b0100_0_1_1_1_1_0_0_0_111_000_000_0, // R4
    22'b0100_0_1_1_1_1_1_0_0_111_000_111_0, // R4
    22'b0011_1_1_1_1_1_0_0_0_110_100_010_1, // R3
    22'b0011_1_1_1_1_1_0_0_0_000_010_001_1, // R3
    22'b0011_1_1_1_1_1_0_0_0_111_001_010_1, // R3
    22'b0011_1_1_1_1_1_0_0_0_011_001_100_1, // R3
    22'b0011_1_1_1_1_1_0_0_0_100_100_001_1, // R3
    22'b0011_1_1_1_1_1_0_0_0_001_010_100_1, // R3
    22'b0100_1_1_1_1_1_0_0_0_010_000_000_0, // R4
    22'b0100_1_1_1_1_1_0_0_0_101_000_000_0, // R4
    22'b0100_1_1_1_1_1_1_0_0_101_000_111_0, // R4
    22'b0101_0_0_1_1_1_0_0_0_100_010_100_1, // R5
    22'b0101_0_0_1_1_1_0_0_0_110_001_100_1, // R5
    22'b0101_1_0_1_1_1_0_0_0_000_001_010_1, // R5
    22'b0110_0_1_0_1_1_0_0_0_100_000_000_0, // R6
    22'b0110_0_1_0_1_1_1_0_0_100_000_111_0, // R6
    22'b0111_0_1_1_1_1_1_0_0_010_000_111_1, // R7
    22'b0111_0_1_1_1_1_1_1_0_010_000_111_1, // R7
    22'b1000_0_1_1_1_1_0_1_0_010_000_000_1, // R8
    22'b1001_0_1_1_1_0_0_0_0_010_010_000_1, // R9
    22'b1001_0_1_1_0_0_0_0_0_010_000_000_1, // R9
    22'b1001_0_1_1_0_1_0_0_0_010_010_001_1, // R9
    22'b1001_0_1_1_1_0_0_0_0_101_001_000_1, // R9
    22'b1011_0_1_1_1_1_0_0_1_010_000_000_0, // R11
    22'b1011_0_1_1_1_1_1_0_1_010_000_000_0, // R11
    22'b1100_0_1_1_0_1_0_0_0_011_010_100_1  // R12
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic setSteady();
    spacing60 = 0; forward = 1; enable = 1; quadSel = 1;
    pwmIn = 1; brake = 0; overCurrent = 0; underVolt = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int high;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "gateTop", gateTop, 0);
    check("R1", "gateBot", gateBot, 0);
    check("R1", "tachOut", tachOut, 0);
    check("R1", "faultN",  faultN,  1);
    rstN = 1'b1;

    // table of vectors
    for (int v = 0; v < NVEC; v++) begin
      logic [21:0] e;
      string tag;
      e = VEC[v];
      tag = $sformatf("R%0d", e[21:18]);
      @(negedge clk);
      spacing60 = e[17]; forward = e[16]; enable = e[15]; quadSel = e[14];
      pwmIn = e[13]; brake = e[12]; overCurrent = e[11]; underVolt = e[10];
      hallIn = e[9:7];
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(tag, $sformatf("vec%0d gateTop", v), gateTop, e[6:4]);
      check(tag, $sformatf("vec%0d gateBot", v), gateBot, e[3:1]);
      check(tag, $sformatf("vec%0d faultN", v),  faultN,  e[0]);
    end

    // R2 latency: sensor change reaches gates on third edge
    @(negedge clk);
    setSteady(); hallIn = 3'b100;
    repeat (TACH_N + 6) @(posedge clk);
    @(negedge clk);
    hallIn = 3'b110;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R2", "latency gateBot after 2 edges", gateBot, 3'b010);
    check("R10", "tach after 2 edges", tachOut, 0);
    @(posedge clk);
    @(negedge clk);
    check("R2", "latency gateBot after 3 edges", gateBot, 3'b001);
    check("R10", "tach after 3 edges", tachOut, 1);
    high = 1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (tachOut) high++;
    end
    check("R10", "tach width", high, TACH_N);

    // R2: control input acts on next edge
    @(negedge clk);
    pwmIn = 0;
    @(posedge clk);
    @(negedge clk);
    check("R9", "pwm on next edge gateBot", gateBot, 0);
    check("R9", "pwm on next edge gateTop", gateTop, 3'b100);
    pwmIn = 1;

    // R10 retrigger: second change two cycles after first
    repeat (TACH_N + 6) @(posedge clk);
    @(negedge clk);
    hallIn = 3'b010;
    repeat (2) @(posedge clk);
    @(negedge clk);
    hallIn = 3'b011;
    high = 0;
    for (int c = 0; c < 25; c++) begin
      @(negedge clk);
      if (tachOut) high++;
    end
    check("R10", "tach retrigger width", high, TACH_N + 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule